// File: doc/BRIEF.md
# Pipelined Euclidean Distance Unit

This block returns the integer length of the hypotenuse, c = floor(sqrt(a*a + b*b)), for two unsigned operands. The work is cut into three fixed steps: the first step squares both operands and registers the two squares, the second adds the registered squares and registers the sum, and the third extracts the integer square root of that sum in one combinational array. The block is fully pipelined, so it can take a fresh operand pair on every clock and retire one result per clock.

A single valid bit runs beside the data through each register step. The result and its valid flag are aligned two cycles behind the step in which the operands are presented. With the default 8-bit operands the sum is 17 bits wide and the root is 9 bits wide. An optional output register can be switched on by parameter, which adds one cycle of latency. Reset is synchronous and drops every valid bit, so any pair still in flight is discarded.

Top module: `euclid_dist_pipe`

## Requirements
- R1: When `res_vld` is high, `res_c` equals floor(sqrt(a*a + b*b)) of the pair it belongs to, as a 9-bit unsigned value (default widths).
- R2: A pair sampled on a rising edge with `op_vld` high appears on `res_c` with `res_vld` high after the second following rising edge (latency 2 with `OUT_REG` = 0).
- R3: A new pair may be presented on every clock; back-to-back pairs produce back-to-back results in the order presented.
- R4: `res_vld` is high in a cycle exactly when `op_vld` was high two edges earlier, so gaps in the input stream show as equal gaps in the output stream.
- R5: `res_c` reads zero whenever `res_vld` is low.
- R6: Synchronous reset clears all valid bits: after a rising edge with `rst` high, `res_vld` is low and `res_c` is zero, and pairs in flight at that edge never appear.
- R7: Operands 9 and 12 give a result of 15.
- R8: Range corners are exact: 0,0 gives 0; 255,255 gives 360; 255,0 and 0,255 give 255; 254,255 gives 359 (sum just below 360 squared).
- R9: Operand values presented with `op_vld` low have no effect: they produce no result and leave `res_c` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_vld | input | 1 | Operand pair is valid this cycle |
| op_a | input | IN_W (8) | First operand, unsigned |
| op_b | input | IN_W (8) | Second operand, unsigned |
| res_vld | output | 1 | Result is valid this cycle |
| res_c | output | IN_W+1 (9) | Integer square root of the sum of squares |

## Verification
A table of known pairs is streamed back to back: exact right triangles such as 3,4 and 5,12 tell a correct root from one that is off by one, while pairs like 4,4 and 254,255 whose sums fall just under a perfect square tell the floor from rounding. The largest operands test the top bits of the sum and root, and zero operands test the bottom. An alternating valid pattern with junk data in the idle slots separates honest valid alignment from a design that lets idle data leak through or shifts results by a cycle, and a long random back-to-back run against a delayed reference model checks ordering at full rate. A reset asserted with pairs in flight shows whether stale results escape.

// File: rtl/euclid_pkg.sv
package euclid_pkg;

   // Widest operand the square helper accepts.
   localparam int unsigned MAX_OP_W = 32;

   // Square variants selectable at elaboration.
   localparam int unsigned SQ_MUL       = 0;
   localparam int unsigned SQ_SHIFT_ADD = 1;

   // Root width needed for a sum of two squares of op_w bits.
   function automatic int unsigned root_width(input int unsigned op_w);
      return op_w + 1;
   endfunction

   // Square built from shifted partial products, no multiplier operator.
   function automatic logic [2*MAX_OP_W-1:0] shift_add_square(input logic [MAX_OP_W-1:0] x);
      logic [2*MAX_OP_W-1:0] acc;
      acc = '0;
      for (int i = 0; i < MAX_OP_W; i++) begin
         if (x[i]) acc = acc + ({{MAX_OP_W{1'b0}}, x} << i);
      end
      return acc;
   endfunction

endpackage

// File: rtl/euclid_sq_stage.sv
module euclid_sq_stage #(
   parameter int unsigned IN_W     = 8,
   parameter int unsigned SQ_STYLE = 0,
   localparam int unsigned SQ_W    = 2 * IN_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_vld,
   input  logic [IN_W-1:0] in_a,
   input  logic [IN_W-1:0] in_b,
   output logic            sq_vld,
   output logic [SQ_W-1:0] sq_a,
   output logic [SQ_W-1:0] sq_b
);

   logic [SQ_W-1:0] sq_a_d;
   logic [SQ_W-1:0] sq_b_d;

   generate
      if (SQ_STYLE == euclid_pkg::SQ_MUL) begin : g_mul
         always_comb begin
            sq_a_d = SQ_W'(in_a) * SQ_W'(in_a);
            sq_b_d = SQ_W'(in_b) * SQ_W'(in_b);
         end
      end else begin : g_shift_add
         always_comb begin
            sq_a_d = SQ_W'(euclid_pkg::shift_add_square(euclid_pkg::MAX_OP_W'(in_a)));
            sq_b_d = SQ_W'(euclid_pkg::shift_add_square(euclid_pkg::MAX_OP_W'(in_b)));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sq_vld <= 1'b0;
         sq_a   <= '0;
         sq_b   <= '0;
      end else begin
         sq_vld <= in_vld;
         if (in_vld) begin
            sq_a <= sq_a_d;
            sq_b <= sq_b_d;
         end
      end
   end

endmodule

// File: rtl/euclid_sum_stage.sv
module euclid_sum_stage #(
   parameter int unsigned SQ_W  = 16,
   localparam int unsigned SUM_W = SQ_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sq_vld,
   input  logic [SQ_W-1:0]  sq_a,
   input  logic [SQ_W-1:0]  sq_b,
   output logic             sum_vld,
   output logic [SUM_W-1:0] sum
);

   logic [SUM_W-1:0] sum_d;

   always_comb sum_d = SUM_W'(sq_a) + SUM_W'(sq_b);

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_vld <= 1'b0;
         sum     <= '0;
      end else begin
         sum_vld <= sq_vld;
         if (sq_vld) sum <= sum_d;
      end
   end

endmodule

// File: rtl/euclid_root_stage.sv
module euclid_root_stage #(
   parameter int unsigned SUM_W   = 17,
   parameter int unsigned ROOT_W  = 9,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sum_vld,
   input  logic [SUM_W-1:0]  sum,
   output logic              root_vld,
   output logic [ROOT_W-1:0] root
);

   localparam int unsigned PAD_W = 2 * ROOT_W;
   localparam int unsigned REM_W = ROOT_W + 4;

   logic [PAD_W-1:0]  radicand;
   logic [REM_W-1:0]  rem_row  [ROOT_W+1];
   logic [ROOT_W-1:0] root_row [ROOT_W+1];
   logic [ROOT_W-1:0] root_comb;

   always_comb radicand = PAD_W'(sum);

   assign rem_row[0]  = '0;
   assign root_row[0] = '0;

   // One row per result bit, most significant digit pair first.
   generate
      for (genvar k = 0; k < ROOT_W; k++) begin : g_row
         localparam int unsigned PAIR = ROOT_W - 1 - k;
         logic [REM_W-1:0] rem_sh;
         logic [REM_W-1:0] trial;
         logic             take;
         always_comb begin
            rem_sh = {rem_row[k][REM_W-3:0], radicand[2*PAIR+1 -: 2]};
            trial  = REM_W'({root_row[k], 2'b01});
            take   = (rem_sh >= trial);
         end
         assign rem_row[k+1]  = take ? (rem_sh - trial) : rem_sh;
         assign root_row[k+1] = {root_row[k][ROOT_W-2:0], take};
      end
   endgenerate

   always_comb root_comb = sum_vld ? root_row[ROOT_W] : '0;

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               root_vld <= 1'b0;
               root     <= '0;
            end else begin
               root_vld <= sum_vld;
               root     <= root_comb;
            end
         end
      end else begin : g_out_comb
         assign root_vld = sum_vld;
         assign root     = root_comb;
      end
   endgenerate

endmodule

// File: rtl/euclid_dist_pipe.sv
module euclid_dist_pipe #(
   parameter int unsigned IN_W     = 8,
   parameter int unsigned SQ_STYLE = 0,
   parameter bit          OUT_REG  = 1'b0,
   localparam int unsigned SQ_W    = 2 * IN_W,
   localparam int unsigned SUM_W   = SQ_W + 1,
   localparam int unsigned ROOT_W  = IN_W + 1,
   localparam int unsigned LAT     = 2 + int'(OUT_REG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_vld,
   input  logic [IN_W-1:0]   op_a,
   input  logic [IN_W-1:0]   op_b,
   output logic              res_vld,
   output logic [ROOT_W-1:0] res_c
);

   if (IN_W < 2 || IN_W > euclid_pkg::MAX_OP_W) begin : g_bad_width
      $error("euclid_dist_pipe: IN_W out of range");
   end
   if (SQ_STYLE > euclid_pkg::SQ_SHIFT_ADD) begin : g_bad_style
      $error("euclid_dist_pipe: unknown SQ_STYLE");
   end
   if (ROOT_W != euclid_pkg::root_width(IN_W) || 2 * ROOT_W < SUM_W) begin : g_bad_root
      $error("euclid_dist_pipe: root width does not cover the sum");
   end

   logic             sq_vld;
   logic [SQ_W-1:0]  sq_a;
   logic [SQ_W-1:0]  sq_b;
   logic             sum_vld;
   logic [SUM_W-1:0] sum;

   euclid_sq_stage #(.IN_W(IN_W), .SQ_STYLE(SQ_STYLE)) u_sq (
      .clk(clk), .rst(rst), .in_vld(op_vld), .in_a(op_a), .in_b(op_b),
      .sq_vld(sq_vld), .sq_a(sq_a), .sq_b(sq_b)
   );

   euclid_sum_stage #(.SQ_W(SQ_W)) u_sum (
      .clk(clk), .rst(rst), .sq_vld(sq_vld), .sq_a(sq_a), .sq_b(sq_b),
      .sum_vld(sum_vld), .sum(sum)
   );

   euclid_root_stage #(.SUM_W(SUM_W), .ROOT_W(ROOT_W), .OUT_REG(OUT_REG)) u_root (
      .clk(clk), .rst(rst), .sum_vld(sum_vld), .sum(sum),
      .root_vld(res_vld), .root(res_c)
   );

endmodule

// File: rtl/euclid_dist_chk.sv
module euclid_dist_chk #(
   parameter int unsigned IN_W = 8,
   parameter int unsigned LAT  = 2
) (
   input logic            clk,
   input logic            rst,
   input logic            op_vld,
   input logic [IN_W-1:0] op_a,
   input logic [IN_W-1:0] op_b,
   input logic            res_vld,
   input logic [IN_W:0]   res_c
);

   logic [63:0] in_sumsq;
   logic [63:0] c_w;
   logic [3:0]  since_rst;

   always_comb begin
      in_sumsq = 64'(op_a) * 64'(op_a) + 64'(op_b) * 64'(op_b);
      c_w      = 64'(res_c);
   end

   always_ff @(posedge clk) begin
      if (rst) since_rst <= '0;
      else if (since_rst < 4'(LAT)) since_rst <= since_rst + 4'd1;
   end

   // R1
   root_floor_chk: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 4'(LAT) && res_vld) |->
         (c_w * c_w <= $past(in_sumsq, LAT)) && ((c_w + 1) * (c_w + 1) > $past(in_sumsq, LAT)));

   // R4
   vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 4'(LAT)) |-> (res_vld == $past(op_vld, LAT)));

   // R5
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !res_vld |-> (res_c == '0));

   // R6
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!res_vld && res_c == '0));

endmodule

bind euclid_dist_pipe euclid_dist_chk #(.IN_W(IN_W), .LAT(LAT)) u_chk (
   .clk(clk), .rst(rst), .op_vld(op_vld), .op_a(op_a), .op_b(op_b),
   .res_vld(res_vld), .res_c(res_c)
);

// File: tb/euclid_dist_pipe_bench.sv
`timescale 1ns/1ps
module euclid_dist_pipe_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       op_vld = 1'b0;
   logic [7:0] op_a = '0;
   logic [7:0] op_b = '0;
   logic       res_vld;
   logic [8:0] res_c;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // expected pipeline: index 1 is the pair due at the next sample
   logic       ev [2];
   logic [8:0] ec [2];

   always #2.5 clk = ~clk;

   euclid_dist_pipe u_euclid_dist_pipe (
      .clk(clk), .rst(rst), .op_vld(op_vld), .op_a(op_a), .op_b(op_b),
      .res_vld(res_vld), .res_c(res_c)
   );

   // {a, b, expected c}
   localparam logic [24:0] VEC [18] = '{
      {8'd9,   8'd12,  9'd15},   // R7
      {8'd3,   8'd4,   9'd5},
      {8'd0,   8'd0,   9'd0},    // R8
      {8'd1,   8'd1,   9'd1},
      {8'd255, 8'd255, 9'd360},  // R8
      {8'd255, 8'd0,   9'd255},  // R8
      {8'd0,   8'd255, 9'd255},  // R8
      {8'd254, 8'd255, 9'd359},  // R8
      {8'd5,   8'd12,  9'd13},
      {8'd8,   8'd15,  9'd17},
      {8'd2,   8'd3,   9'd3},
      {8'd4,   8'd4,   9'd5},
      {8'd100, 8'd100, 9'd141},
      {8'd200, 8'd150, 9'd250},
      {8'd7,   8'd24,  9'd25},
      {8'd20,  8'd21,  9'd29},
      {8'd1,   8'd0,   9'd1},
      {8'd6,   8'd8,   9'd10}
   };

   function automatic logic [8:0] ref_root(input logic [7:0] a, input logic [7:0] b);
      int s = int'(a) * int'(a) + int'(b) * int'(b);
      int r = 0;
      while ((r + 1) * (r + 1) <= s) r++;
      return 9'(r);
   endfunction

   task automatic check(input string tag, input logic exp_v, input logic [8:0] exp_c);
      n_chk++;
      if (res_vld !== exp_v || res_c !== exp_c) begin
         n_fail++;
         $display("FAIL %s: got vld=%0b c=%0d, expected vld=%0b c=%0d",
                  tag, res_vld, res_c, exp_v, exp_c);
      end
   endtask

   // One cycle: sample outputs due now, then drive the next inputs.
   task automatic step(input string tag, input logic v, input logic [7:0] a,
                       input logic [7:0] b, input logic r);
      @(negedge clk);
      check(tag, ev[1], ev[1] ? ec[1] : 9'd0);
      ev[1] = ev[0];
      ec[1] = ec[0];
      ev[0] = v;
      ec[0] = ref_root(a, b);
      if (r) begin
         ev[0] = 1'b0;
         ev[1] = 1'b0;
      end
      rst    = r;
      op_vld = v;
      op_a   = a;
      op_b   = b;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got run still active, expected completion");
      finish_run();
   end

   initial begin
      ev[0] = 1'b0; ev[1] = 1'b0; ec[0] = '0; ec[1] = '0;
      // R6: reset state, with junk valid data held during reset
      op_vld = 1'b1; op_a = 8'd77; op_b = 8'd33;
      repeat (3) @(negedge clk);
      check("R6 reset state", 1'b0, 9'd0);
      op_vld = 1'b0;

      // R1 R2 R7 R8: table streamed back to back
      for (int i = 0; i < 18; i++)
         step("R1 R2 R7 R8 table", 1'b1, VEC[i][24:17], VEC[i][16:9], 1'b0);
      for (int i = 0; i < 3; i++) step("R2 drain", 1'b0, 8'd0, 8'd0, 1'b0);

      // direct table comparison on a fresh pass, independent of ref_root
      for (int i = 0; i < 18; i++) begin
         @(negedge clk);
         op_vld = 1'b1; op_a = VEC[i][24:17]; op_b = VEC[i][16:9];
         @(negedge clk);
         op_vld = 1'b0; op_a = 8'hA5; op_b = 8'h5A;
         @(negedge clk);
         check("R1 R7 R8 table value", 1'b1, VEC[i][8:0]);
      end
      @(negedge clk);
      check("R5 idle after table", 1'b0, 9'd0);
      ev[0] = 1'b0; ev[1] = 1'b0;

      // R4 R9 R5: alternating valid, junk operands in idle slots
      for (int i = 0; i < 40; i++)
         step("R4 R5 R9 gaps", (i % 2) == 0, 8'($urandom_range(255)),
              8'($urandom_range(255)), 1'b0);
      for (int i = 0; i < 20; i++)
         step("R4 R9 sparse", (i % 3) == 1, 8'($urandom_range(255)),
              8'($urandom_range(255)), 1'b0);

      // R3: random back-to-back stream
      for (int i = 0; i < 400; i++)
         step("R3 back-to-back", 1'b1, 8'($urandom_range(255)),
              8'($urandom_range(255)), 1'b0);

      // R6: reset with pairs in flight
      step("R3 pre-reset", 1'b1, 8'd30, 8'd40, 1'b0);
      step("R6 reset in flight", 1'b1, 8'd50, 8'd120, 1'b1);
      step("R6 flushed", 1'b0, 8'd0, 8'd0, 1'b0);
      step("R6 flushed", 1'b1, 8'd9, 8'd12, 1'b0);
      step("R6 flushed", 1'b0, 8'd0, 8'd0, 1'b0);
      step("R6 R7 restart", 1'b0, 8'd0, 8'd0, 1'b0);
      step("R5 drain", 1'b0, 8'd0, 8'd0, 1'b0);
      finish_run();
   end

endmodule